// File: doc/BRIEF.md
# Two-Way Crossing Light Sequencer

This block drives the red, yellow and green lamps of two crossing signals, named A and B. It keeps no time of its own. One external pacing input decides when each change of lights happens. Whatever sits upstream, such as a timer, a host or a test fixture, raises the pacing input to start a warning phase. It lowers the input again to hand right of way to the other signal. As a result, a yellow phase lasts exactly as long as the pacing input stays high.

Inside, the block is a ring of four phases held in one flip-flop per phase. The ring advances on a rising clock edge when the sampled pacing level is the one that leaves the current phase: a high level leaves a green phase, and a low level leaves a yellow phase. The lamp outputs are registered Moore outputs and track the phase flops. The reset is synchronous and active high.

Top module: `xing_sequencer`

## Requirements
- R1: When `rst` is high at a rising clock edge, the lamps after that edge are A green and B red, whatever the level of `pace`.
- R2: From A green / B red, a high `pace` sampled at a rising edge gives A yellow / B red right after that same edge.
- R3: From A yellow / B red, a low `pace` sampled at a rising edge gives A red / B green right after that edge.
- R4: From A red / B green, a high `pace` sampled at a rising edge gives A red / B yellow right after that edge.
- R5: From A red / B yellow, a low `pace` sampled at a rising edge gives A green / B red right after that edge.
- R6: A green phase holds for any number of cycles while `pace` stays low, and a yellow phase holds for any number of cycles while `pace` stays high.
- R7: Each lamp output is a 3-bit vector with bit 0 red, bit 1 yellow and bit 2 green, and exactly one of its bits is set after every clock edge.
- R8: At no time are both signals showing a lamp other than red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to A green / B red |
| pace | input | 1 | External pacing level that triggers every phase change |
| sig_a_lamp | output | 3 | Signal A lamps: bit 0 red, bit 1 yellow, bit 2 green |
| sig_b_lamp | output | 3 | Signal B lamps: bit 0 red, bit 1 yellow, bit 2 green |

## Verification
The pacing input is first held for several cycles in each phase. This separates a phase that correctly holds from one that advances on level rather than on the leaving condition. It is then toggled every cycle, so each phase lasts a single cycle, which exposes a wrong next-phase order or an extra cycle of delay. Reset is applied both at start-up with `pace` high and in the middle of a B-green phase, which shows that reset beats the pacing input from any phase.

// File: rtl/xing_pkg.sv
package xing_pkg;
  localparam int NUM_SIGNALS = 2;
  localparam int NUM_PHASES  = 2 * NUM_SIGNALS;
  localparam int LAMP_W      = 3;

  localparam int BIT_RED = 0;
  localparam int BIT_YEL = 1;
  localparam int BIT_GRN = 2;

  typedef logic [LAMP_W-1:0] lamp_t;

  localparam lamp_t LAMP_RED = lamp_t'(1 << BIT_RED);
  localparam lamp_t LAMP_YEL = lamp_t'(1 << BIT_YEL);
  localparam lamp_t LAMP_GRN = lamp_t'(1 << BIT_GRN);
endpackage

// File: rtl/xing_phase_ring.sv
// One flip-flop per phase. Even phases are green phases and leave on a
// high pacing level; odd phases are yellow phases and leave on a low level.
module xing_phase_ring #(
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pace,
  output logic [NUM-1:0] phase_q,
  output logic [NUM-1:0] phase_d
);
  for (genvar i = 0; i < NUM; i++) begin : g_flop
    localparam int  PREV       = (i + NUM - 1) % NUM;
    localparam bit  EXIT_HI    = ((i % 2) == 0);
    localparam bit  PREV_EXIT  = ((PREV % 2) == 0);
    localparam bit  RESET_VAL  = (i == 0);

    logic stay, enter;
    assign stay  = phase_q[i]    & (pace != EXIT_HI);
    assign enter = phase_q[PREV] & (pace == PREV_EXIT);
    assign phase_d[i] = stay | enter;

    always_ff @(posedge clk) begin
      if (rst) phase_q[i] <= RESET_VAL;
      else     phase_q[i] <= phase_d[i];
    end
  end
endmodule

// File: rtl/xing_lamp_decode.sv
// Signal SIDE owns phase 2*SIDE (green) and 2*SIDE+1 (yellow); red otherwise.
module xing_lamp_decode
  import xing_pkg::*;
#(
  parameter int NUM  = 4,
  parameter int SIDE = 0
) (
  input  logic [NUM-1:0] phase,
  output lamp_t          lamp
);
  localparam int GRN_PH = 2 * SIDE;
  localparam int YEL_PH = 2 * SIDE + 1;

  always_comb begin
    lamp          = '0;
    lamp[BIT_GRN] = phase[GRN_PH];
    lamp[BIT_YEL] = phase[YEL_PH];
    lamp[BIT_RED] = ~(phase[GRN_PH] | phase[YEL_PH]);
  end
endmodule

// File: rtl/xing_sequencer.sv
module xing_sequencer
  import xing_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pace,
  output logic [2:0] sig_a_lamp,
  output logic [2:0] sig_b_lamp
);
  logic [NUM_PHASES-1:0] phase_q;
  logic [NUM_PHASES-1:0] phase_d;
  lamp_t                 lamp_q [NUM_SIGNALS];

  xing_phase_ring #(.NUM(NUM_PHASES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .pace    (pace),
    .phase_q (phase_q),
    .phase_d (phase_d)
  );

  // Lamp registers are loaded from the next phase so they change on the
  // same edge as the phase flops.
  for (genvar s = 0; s < NUM_SIGNALS; s++) begin : g_sig
    lamp_t lamp_next;

    xing_lamp_decode #(.NUM(NUM_PHASES), .SIDE(s)) u_dec (
      .phase (phase_d),
      .lamp  (lamp_next)
    );

    always_ff @(posedge clk) begin
      if (rst) lamp_q[s] <= (s == 0) ? LAMP_GRN : LAMP_RED;
      else     lamp_q[s] <= lamp_next;
    end
  end

  assign sig_a_lamp = lamp_q[0];
  assign sig_b_lamp = lamp_q[1];
endmodule

// File: rtl/xing_checker.sv
module xing_checker
  import xing_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  pace,
  input logic [2:0]            lamp_a,
  input logic [2:0]            lamp_b,
  input logic [NUM_PHASES-1:0] phase
);
  AST_RESET_PHASE: assert property (@(posedge clk) $fell(rst) |-> (lamp_a == LAMP_GRN && lamp_b == LAMP_RED)); // R1
  AST_A_TO_YELLOW: assert property (@(posedge clk) disable iff (rst) (lamp_a == LAMP_GRN && pace) |=> (lamp_a == LAMP_YEL && lamp_b == LAMP_RED)); // R2
  AST_A_TO_RED: assert property (@(posedge clk) disable iff (rst) (lamp_a == LAMP_YEL && !pace) |=> (lamp_a == LAMP_RED && lamp_b == LAMP_GRN)); // R3
  AST_B_TO_YELLOW: assert property (@(posedge clk) disable iff (rst) (lamp_b == LAMP_GRN && pace) |=> (lamp_a == LAMP_RED && lamp_b == LAMP_YEL)); // R4
  AST_B_TO_RED: assert property (@(posedge clk) disable iff (rst) (lamp_b == LAMP_YEL && !pace) |=> (lamp_a == LAMP_GRN && lamp_b == LAMP_RED)); // R5
  AST_GREEN_HOLDS: assert property (@(posedge clk) disable iff (rst) ((lamp_a == LAMP_GRN || lamp_b == LAMP_GRN) && !pace) |=> ($stable(lamp_a) && $stable(lamp_b))); // R6
  AST_YELLOW_HOLDS: assert property (@(posedge clk) disable iff (rst) ((lamp_a == LAMP_YEL || lamp_b == LAMP_YEL) && pace) |=> ($stable(lamp_a) && $stable(lamp_b))); // R6
  AST_ONE_LAMP_A: assert property (@(posedge clk) disable iff (rst) $countones(lamp_a) == 1); // R7
  AST_ONE_LAMP_B: assert property (@(posedge clk) disable iff (rst) $countones(lamp_b) == 1); // R7
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst) $countones(phase) == 1); // R7
  AST_NO_SHARED_GO: assert property (@(posedge clk) disable iff (rst) (lamp_a[BIT_RED] || lamp_b[BIT_RED])); // R8
endmodule

bind xing_sequencer xing_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .pace   (pace),
  .lamp_a (sig_a_lamp),
  .lamp_b (sig_b_lamp),
  .phase  (phase_q)
);

// File: tb/test_xing_sequencer.sv
`timescale 1ns/1ps
module test_xing_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pace = 1'b1;
  logic [2:0] sig_a_lamp, sig_b_lamp;

  int n_checks = 0;
  int n_fail   = 0;
  int model_ph = 0;
  bit done     = 1'b0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  xing_sequencer i_xing_sequencer (
    .clk        (clk),
    .rst        (rst),
    .pace       (pace),
    .sig_a_lamp (sig_a_lamp),
    .sig_b_lamp (sig_b_lamp)
  );

  // Encoding from R7: bit0 red, bit1 yellow, bit2 green; {A, B}.
  function automatic logic [5:0] lamps_of(input int ph);
    case (ph)
      0:       return {3'b100, 3'b001};
      1:       return {3'b010, 3'b001};
      2:       return {3'b001, 3'b100};
      default: return {3'b001, 3'b010};
    endcase
  endfunction

  task automatic drive(input logic rst_v, input logic t_v, input string tag);
    @(negedge clk);
    rst  = rst_v;
    pace = t_v;
    if (rst_v) model_ph = 0;
    else if ((model_ph % 2 == 0) && t_v)  model_ph = (model_ph + 1) % 4;
    else if ((model_ph % 2 == 1) && !t_v) model_ph = (model_ph + 1) % 4;
    exp_q.push_back(lamps_of(model_ph));
    tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual A=%b B=%b expected A=%b B=%b", tag, act[5:3], act[2:0], exp[5:3], exp[2:0]);
    end
  endtask

  // Monitor: compares just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] e, a;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {sig_a_lamp, sig_b_lamp};
        check(a === e, t, a, e);
        check($countones(sig_a_lamp) == 1 && $countones(sig_b_lamp) == 1, "R7", a, e);
        check(sig_a_lamp[0] || sig_b_lamp[0], "R8", a, e);
      end
    end
  end

  initial begin
    drive(1, 1, "R1");
    drive(1, 1, "R1");
    for (int i = 0; i < 3; i++) drive(0, 0, "R6");
    drive(0, 1, "R2");
    for (int i = 0; i < 3; i++) drive(0, 1, "R6");
    drive(0, 0, "R3");
    for (int i = 0; i < 2; i++) drive(0, 0, "R6");
    drive(0, 1, "R4");
    for (int i = 0; i < 2; i++) drive(0, 1, "R6");
    drive(0, 0, "R5");
    // Single-cycle phases: pace toggles every cycle.
    for (int i = 0; i < 8; i++) begin
      case (model_ph)
        0:       drive(0, 1, "R2");
        1:       drive(0, 0, "R3");
        2:       drive(0, 1, "R4");
        default: drive(0, 0, "R5");
      endcase
    end
    drive(0, 1, "R2");
    drive(0, 0, "R3");
    drive(0, 0, "R6");
    drive(1, 1, "R1");
    drive(0, 0, "R6");
    drive(0, 1, "R2");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule